// File: doc/BRIEF.md
# Indexed Video Sequencer Register File

This block is a small register bank for a display controller, reached through two byte-wide I/O ports. The index port holds a register number, and it can be read back. The data port reads or writes whichever register that number names. Five registers are held locally: a sequencer reset byte, a clocking control byte, a plane write mask, a character font select byte and a memory organisation byte. Any higher number is passed to an optional extension interface.

Besides the read path, the block decodes its registers into control outputs for the rest of the display engine:

- a 4-bit plane write enable;
- two 3-bit font numbers, each with a 16-bit font base byte address;
- flags for chained (four-plane packed) addressing, odd/even addressing and text mode;
- a screen blank flag;
- a single-cycle pulse that tells downstream timing logic to re-derive its settings after a clocking change.

Top module: `vseq_regbank`

## Requirements
- R1: A synchronous active-high reset sets the index and all five local registers to 0. As a result every decoded output is 0 and no pulse is raised.
- R2: A write with `port_sel`=0 latches all 8 bits of `wdata` as the index. A read with `port_sel`=0 returns the index, and `ext_index` always shows it.
- R3: With `port_sel`=1 and index 0, 1, 3 or 4, a write stores all 8 bits (reset byte, clocking byte, font select byte, memory byte). A later read returns that value.
- R4: Index 2 (plane mask) keeps only `wdata[3:0]` and reads back as {4'b0, mask}. `plane_we[n]` enables writes to plane n.
- R5: Font number A (attribute bit 3 clear) is {fontsel[1:0], fontsel[4]}. Font number B (attribute bit 3 set) is {fontsel[3:2], fontsel[5]}.
- R6: Each font base address is the font number times 8192, i.e. {font, 13'b0}, within a 64 KiB space.
- R7: From the memory byte, `chained` = bit 3, `odd_even` = bit 2 and `text_mode` = bit 0.
- R8: `screen_off` equals bit 5 of the clocking byte.
- R9: `retime_pulse` is high for exactly one cycle, in the cycle after a write to index 1 that changes any clocking bit other than bit 5. A write that changes only bit 5, or rewrites the same value, raises no pulse.
- R10: For index above 4 with `ext_present`=1, a data write raises `ext_wr` and a data read raises `ext_rd`, both in the same cycle. The read returns `ext_rdata`.
- R11: For index above 4 with `ext_present`=0, a data write changes no register and raises no strobe, and a data read returns 0.
- R12: A read of a register in the same cycle as a write to it returns the old value. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_sel | input | 1 | 0 selects the index port, 1 the data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (forwarded to the extension only) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| ext_present | input | 1 | An extension register set is attached |
| ext_rdata | input | 8 | Read data from the extension |
| ext_index | output | 8 | Current index, for the extension |
| ext_wr | output | 1 | Extension write strobe |
| ext_rd | output | 1 | Extension read strobe |
| plane_we | output | 4 | Plane write enables |
| font_a | output | 3 | Font number, attribute bit 3 clear |
| font_b | output | 3 | Font number, attribute bit 3 set |
| font_a_base | output | 16 | Byte base of font A |
| font_b_base | output | 16 | Byte base of font B |
| chained | output | 1 | Chained plane addressing |
| odd_even | output | 1 | Odd/even addressing |
| text_mode | output | 1 | Alphanumeric mode |
| screen_off | output | 1 | Screen blanked |
| retime_pulse | output | 1 | One-cycle clocking reconfiguration pulse |

## Verification
The assertions assume that the strobes and `port_sel` are stable, known values at each rising edge, and that `ext_rdata` is only of interest while the index is above 4. They also assume that a write and a read to the same port may share a cycle. The bench drives every input at the falling edge from tasks, so each edge sees settled values. It raises `ext_present` only around the extension tests, and it exercises the simultaneous write and read case on purpose.

// File: rtl/vseq_regbank.sv
module vseq_regbank #(
  parameter int DW     = 8,
  parameter int PLANES = 4,
  parameter int FONTW  = 3,
  parameter int FBASEW = 16,
  parameter int NLOCAL = 5,
  parameter int BLANK_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              ext_present,
  input  logic [DW-1:0]     ext_rdata,
  output logic [DW-1:0]     ext_index,
  output logic              ext_wr,
  output logic              ext_rd,
  output logic [PLANES-1:0] plane_we,
  output logic [FONTW-1:0]  font_a,
  output logic [FONTW-1:0]  font_b,
  output logic [FBASEW-1:0] font_a_base,
  output logic [FBASEW-1:0] font_b_base,
  output logic              chained,
  output logic              odd_even,
  output logic              text_mode,
  output logic              screen_off,
  output logic              retime_pulse
);
  localparam int SHIFT = FBASEW - FONTW;
  localparam logic [DW-1:0] I_RST  = DW'(0);
  localparam logic [DW-1:0] I_CLK  = DW'(1);
  localparam logic [DW-1:0] I_MASK = DW'(2);
  localparam logic [DW-1:0] I_FONT = DW'(3);
  localparam logic [DW-1:0] I_MEM  = DW'(4);
  localparam logic [DW-1:0] LAST   = DW'(NLOCAL - 1);
  localparam logic [DW-1:0] KEEP   = ~(DW'(1) << BLANK_BIT);

  logic [DW-1:0]     idx_q, rst_q, clk_q, font_q, mem_q;
  logic [PLANES-1:0] mask_q;
  logic              pulse_q;

  wire data_wr  = wr_en & port_sel;
  wire idx_wr   = wr_en & ~port_sel;
  wire is_ext   = idx_q > LAST;
  wire clk_wr   = data_wr && idx_q == I_CLK;
  wire timing_d = |((wdata ^ clk_q) & KEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      rst_q   <= '0;
      clk_q   <= '0;
      mask_q  <= '0;
      font_q  <= '0;
      mem_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= clk_wr & timing_d;
      if (idx_wr) idx_q <= wdata;
      if (data_wr) begin
        case (idx_q)
          I_RST:   rst_q  <= wdata;
          I_CLK:   clk_q  <= wdata;
          I_MASK:  mask_q <= wdata[PLANES-1:0];
          I_FONT:  font_q <= wdata;
          I_MEM:   mem_q  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    if (!port_sel) rdata = idx_q;
    else begin
      case (idx_q)
        I_RST:   rdata = rst_q;
        I_CLK:   rdata = clk_q;
        I_MASK:  rdata = DW'(mask_q);
        I_FONT:  rdata = font_q;
        I_MEM:   rdata = mem_q;
        default: rdata = ext_present ? ext_rdata : '0;
      endcase
    end
  end

  assign ext_index    = idx_q;
  assign ext_wr       = data_wr & is_ext & ext_present;
  assign ext_rd       = rd_en & port_sel & is_ext & ext_present;
  assign plane_we     = mask_q;
  assign font_a       = {font_q[1:0], font_q[4]};
  assign font_b       = {font_q[3:2], font_q[5]};
  assign font_a_base  = {font_a, SHIFT'(0)};
  assign font_b_base  = {font_b, SHIFT'(0)};
  assign chained      = mem_q[3];
  assign odd_even     = mem_q[2];
  assign text_mode    = mem_q[0];
  assign screen_off   = clk_q[BLANK_BIT];
  assign retime_pulse = pulse_q;
endmodule

// File: rtl/vseq_regbank_chk.sv
module vseq_regbank_chk (
  input logic       clk,
  input logic       rst,
  input logic       port_sel,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       ext_present,
  input logic [7:0] ext_index,
  input logic       ext_wr,
  input logic [3:0] plane_we,
  input logic       screen_off,
  input logic       retime_pulse
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ext_index == 8'h00 && plane_we == 4'h0 && !retime_pulse && !screen_off));

  assert_index_latch_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !port_sel) |=> ext_index == $past(wdata));

  assert_mask_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (port_sel && ext_index == 8'h02) |-> rdata[7:4] == 4'h0);

  assert_blank_bit_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_sel && ext_index == 8'h01) |=> screen_off == $past(wdata[5]));

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    retime_pulse |=> !retime_pulse);

  assert_ext_write_R10: assert property (@(posedge clk) disable iff (rst)
    ext_wr |-> (ext_present && wr_en && port_sel && ext_index > 8'h04));

  assert_absent_read_R11: assert property (@(posedge clk) disable iff (rst)
    (port_sel && ext_index > 8'h04 && !ext_present) |-> rdata == 8'h00);
endmodule

bind vseq_regbank vseq_regbank_chk chk_i (.*);

// File: tb/vseq_regbank_tb_top.sv
module vseq_regbank_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ext_present = 1'b0;
  logic [7:0] wdata = '0, ext_rdata = 8'hA5;
  logic [7:0] rdata, ext_index;
  logic ext_wr, ext_rd, chained, odd_even, text_mode, screen_off, retime_pulse;
  logic [3:0] plane_we;
  logic [2:0] font_a, font_b;
  logic [15:0] font_a_base, font_b_base;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  vseq_regbank dut_i (.*);

  // {is_write, port_sel, data, expected read}
  localparam int NV = 20;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h01, 8'h00}, {1'b0, 1'b0, 8'h00, 8'h01},
    {1'b1, 1'b1, 8'hC5, 8'h00}, {1'b0, 1'b1, 8'h00, 8'hC5},
    {1'b1, 1'b0, 8'h03, 8'h00}, {1'b1, 1'b1, 8'h3F, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h3F}, {1'b1, 1'b0, 8'h02, 8'h00},
    {1'b1, 1'b1, 8'hFF, 8'h00}, {1'b0, 1'b1, 8'h00, 8'h0F},
    {1'b1, 1'b1, 8'hA6, 8'h00}, {1'b0, 1'b1, 8'h00, 8'h06},
    {1'b1, 1'b0, 8'h04, 8'h00}, {1'b1, 1'b1, 8'h0A, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h0A}, {1'b1, 1'b0, 8'h00, 8'h00},
    {1'b1, 1'b1, 8'h03, 8'h00}, {1'b0, 1'b1, 8'h00, 8'h03},
    {1'b1, 1'b0, 8'h01, 8'h00}, {1'b0, 1'b1, 8'h00, 8'hC5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    port_sel = s; wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    port_sel = s; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(1'b0, v); chk("R1 index after reset", v, 8'h00);
    chk("R1 plane_we after reset", plane_we, 4'h0);
    chk("R1 pulse after reset", retime_pulse, 1'b0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17]) wr(VEC[i][16], VEC[i][15:8]);
      else begin
        rd(VEC[i][16], v);
        checks++;
        if (v !== VEC[i][7:0]) begin
          fails++;
          $display("FAIL R2/R3/R4 vector %0d: actual %0h expected %0h", i, v, VEC[i][7:0]);
        end
      end
    end
    chk("R4 plane_we", plane_we, 4'h6);

    wr(1'b0, 8'h03); wr(1'b1, 8'h12);
    chk("R5 font_a 0x12", font_a, 3'd5);
    chk("R5 font_b 0x12", font_b, 3'd0);
    chk("R6 font_a_base 0x12", font_a_base, 16'hA000);
    chk("R6 font_b_base 0x12", font_b_base, 16'h0000);
    wr(1'b1, 8'h2C);
    chk("R5 font_a 0x2C", font_a, 3'd0);
    chk("R5 font_b 0x2C", font_b, 3'd7);
    chk("R6 font_b_base 0x2C", font_b_base, 16'hE000);

    wr(1'b0, 8'h04); wr(1'b1, 8'h0D);
    chk("R7 flags 0x0D", {chained, odd_even, text_mode}, 3'b111);
    wr(1'b1, 8'h02);
    chk("R7 flags 0x02", {chained, odd_even, text_mode}, 3'b000);

    wr(1'b0, 8'h01);
    wr(1'b1, 8'hE5);
    chk("R9 no pulse on blank-only change", retime_pulse, 1'b0);
    chk("R8 screen_off set", screen_off, 1'b1);
    wr(1'b1, 8'hE5);
    chk("R9 no pulse on same value", retime_pulse, 1'b0);
    wr(1'b1, 8'hE4);
    chk("R9 pulse on timing change", retime_pulse, 1'b1);
    @(negedge clk);
    chk("R9 pulse lasts one cycle", retime_pulse, 1'b0);
    wr(1'b1, 8'hC4);
    chk("R8 screen_off cleared", screen_off, 1'b0);

    wr(1'b0, 8'h04);
    @(negedge clk);
    port_sel = 1'b1; wr_en = 1'b1; wdata = 8'h77;
    #1 chk("R12 old value same cycle", rdata, 8'h02);
    @(negedge clk); wr_en = 1'b0;
    rd(1'b1, v); chk("R12 new value next cycle", v, 8'h77);

    wr(1'b0, 8'h07);
    @(negedge clk);
    port_sel = 1'b1; wr_en = 1'b1; wdata = 8'h55;
    #1 chk("R11 no ext_wr when absent", ext_wr, 1'b0);
    @(negedge clk); wr_en = 1'b0;
    rd(1'b1, v); chk("R11 read returns 0", v, 8'h00);
    wr(1'b0, 8'h04); rd(1'b1, v); chk("R11 memory byte untouched", v, 8'h77);
    wr(1'b0, 8'h02); rd(1'b1, v); chk("R11 mask untouched", v, 8'h06);

    ext_present = 1'b1;
    wr(1'b0, 8'h09);
    chk("R10 ext_index", ext_index, 8'h09);
    @(negedge clk);
    port_sel = 1'b1; wr_en = 1'b1; wdata = 8'h33;
    #1 chk("R10 ext_wr raised", ext_wr, 1'b1);
    @(negedge clk); wr_en = 1'b0;
    port_sel = 1'b1; rd_en = 1'b1;
    #1 chk("R10 ext_rd raised", ext_rd, 1'b1);
    chk("R10 ext read data", rdata, 8'hA5);
    rd_en = 1'b0;
    ext_present = 1'b0;

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(1'b0, v); chk("R1 index after mid reset", v, 8'h00);
    chk("R1 outputs after mid reset",
        {plane_we, font_a, font_b, chained, odd_even, text_mode, screen_off}, 14'h0);
    wr(1'b0, 8'h01); rd(1'b1, v); chk("R1 clocking byte cleared", v, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule